// File: doc/BRIEF.md
# Serial Register Load Port

This block accepts configuration words over a three-wire, write-only serial link and turns them into the parameter registers of a frequency-scan engine. The link has an active-low frame input, a serial clock and a data line. While the frame input is low, one bit is taken on each falling edge of the serial clock. Every 16 bits form a word. The top four bits of a word pick a destination and the remaining bits carry its value.

The serial side runs on the serial clock alone. A finished word is marked by flipping a toggle flag. That flag is brought into the system clock through a short synchronizer chain, and each change of the flag produces one decode strobe there. Every register update and the scan-engine reset pulse happen in the system clock domain.

The 24-bit start frequency and the signed 23-bit step are each written in two halves. One bit of the control register selects between two ways of doing this. In paired mode the low half is held back until the high half arrives, so a consumer never sees a half-updated value. In independent mode each half is written directly on its own.

Top module: `serLoadPort`

## Requirements
- R1: On each falling edge of `serClk` while `frameN` is low, the port shifts in one bit of `serData`, most significant bit first. Bits 15:12 of a completed 16-bit word are the address and bits 11:0 are the payload.
- R2: While `frameN` stays low across several 16-bit words, each completed word is applied in turn.
- R3: If `frameN` rises before 16 bits have arrived, the partial word changes nothing. The next frame starts again from bit 15.
- R4: Address 0000 loads payload[11:0] into `ctrlWord`. Every such write raises `scanReset` for exactly one clock.
- R5: Address 0001 loads payload[11:0] into `stepCount`.
- R6: Any address of the form 01xx writes the interval fields. Word bit 13 goes to `intervalByCycles`, word bits 12:11 go to `intervalMult`, and word bits 10:0 go to `intervalLen`.
- R7: With `ctrlWord[11]` = 0, each half is written independently. Address 0010 sets `deltaMag[11:0]`. Address 0011 sets `deltaMag[22:12]` from payload[10:0] and sets `deltaNeg` from payload[11]. Address 1100 sets `startFreq[11:0]` and address 1101 sets `startFreq[23:12]`. Each half leaves the other half unchanged.
- R8: With `ctrlWord[11]` = 1, a low-half write (0010 or 1100) leaves its register unchanged. The following high-half write (0011 or 1101) updates all bits of that register in the same clock, using the held low half.
- R9: Addresses 10xx, 1110 and 1111 change no output and raise no `scanReset`.
- R10: After reset, every register output is zero and `scanReset` is low.
- R11: `serClk` edges while `frameN` is high shift nothing and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| frameN | input | 1 | Active-low frame enable |
| serData | input | 1 | Serial data, MSB first |
| ctrlWord | output | 12 | Control register (bit 11 selects paired loads) |
| stepCount | output | 12 | Number of frequency steps |
| intervalByCycles | output | 1 | Interval counts output cycles (1) or clocks (0) |
| intervalMult | output | 2 | Time-base multiplier code |
| intervalLen | output | 11 | Interval length |
| deltaMag | output | 23 | Step magnitude |
| deltaNeg | output | 1 | Step direction, 1 = decreasing |
| startFreq | output | 24 | Start frequency word |
| scanReset | output | 1 | One-clock reset pulse to the scan engine |

## Verification
The hardest state to reach is a paired-mode low half that is staged but not yet visible. It only exists between two separate serial words, after the control register has already switched modes. The stimulus first writes a control word with bit 11 set. It then sends the low half in its own frame and checks that the outputs are unchanged, and only after that sends the high half. Broken frames and clock edges with the frame high are driven on purpose to show that the bit counter realigns. A reference model kept in the bench predicts every register and the number of reset pulses.

// File: rtl/serload_pkg.sv
package serload_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int HALF_W  = 12;
  localparam int IVAL_W  = 14;
  localparam int DELTA_W = 23;
  localparam int START_W = 2 * HALF_W;
  localparam int CNT_W   = $clog2(WORD_W);

  typedef struct packed {
    logic wrCtrl;
    logic wrCount;
    logic wrInterval;
    logic wrDeltaLo;
    logic wrDeltaHi;
    logic wrStartLo;
    logic wrStartHi;
    logic [IVAL_W-1:0] data;
  } regStrobes_t;
endpackage

// File: rtl/serShifter.sv
module serShifter
  import serload_pkg::*;
(
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              frameN,
  input  logic              serData,
  output logic [WORD_W-1:0] wordHold,
  output logic              wordToggle
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-2:0] shiftReg;

  // Bit position restarts whenever the frame is inactive (R3, R11)
  always_ff @(negedge serClk or posedge frameN or negedge rst_n) begin
    if (!rst_n)      bitCnt <= '0;
    else if (frameN) bitCnt <= '0;
    else             bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  always_ff @(negedge serClk or negedge rst_n) begin
    if (!rst_n)       shiftReg <= '0;
    else if (!frameN) shiftReg <= {shiftReg[WORD_W-3:0], serData};
  end

  always_ff @(negedge serClk or negedge rst_n) begin
    if (!rst_n) begin
      wordHold   <= '0;
      wordToggle <= 1'b0;
    end else if (!frameN && bitCnt == LAST_BIT) begin
      wordHold   <= {shiftReg, serData};
      wordToggle <= ~wordToggle;
    end
  end
endmodule

// File: rtl/serControl.sv
module serControl
  import serload_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wordToggle,
  input  logic [WORD_W-1:0] wordHold,
  output regStrobes_t       strobes
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   toggleSeen;
  logic                   wordPulse;
  logic [ADDR_W-1:0]      addr;
  logic                   isReserved;
  regStrobes_t            nxt;
  logic [6:0]             strobeBits;

  assign wordPulse  = syncChain[SYNC_STAGES-1] ^ toggleSeen;
  assign addr       = wordHold[WORD_W-1 -: ADDR_W];
  assign isReserved = (addr[3:2] == 2'b10) || (addr[3:1] == 3'b111);
  assign strobeBits = {strobes.wrCtrl, strobes.wrCount, strobes.wrInterval,
                       strobes.wrDeltaLo, strobes.wrDeltaHi,
                       strobes.wrStartLo, strobes.wrStartHi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncChain  <= '0;
      toggleSeen <= 1'b0;
    end else begin
      syncChain  <= {syncChain[SYNC_STAGES-2:0], wordToggle};
      toggleSeen <= syncChain[SYNC_STAGES-1];
    end
  end

  always_comb begin
    nxt      = '0;
    nxt.data = wordHold[IVAL_W-1:0];
    if (wordPulse) begin
      casez (addr)
        4'b0000: nxt.wrCtrl     = 1'b1;
        4'b0001: nxt.wrCount    = 1'b1;
        4'b0010: nxt.wrDeltaLo  = 1'b1;
        4'b0011: nxt.wrDeltaHi  = 1'b1;
        4'b01??: nxt.wrInterval = 1'b1;
        4'b1100: nxt.wrStartLo  = 1'b1;
        4'b1101: nxt.wrStartHi  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobes <= '0;
    else        strobes <= nxt;
  end

  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobeBits));
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !wordPulse |=> (strobeBits == '0));
  a_r9_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wordPulse && isReserved) |=> (strobeBits == '0));
endmodule

// File: rtl/serRegFile.sv
module serRegFile
  import serload_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobes_t        strobes,
  output logic [HALF_W-1:0]  ctrlWord,
  output logic [HALF_W-1:0]  stepCount,
  output logic               intervalByCycles,
  output logic [1:0]         intervalMult,
  output logic [10:0]        intervalLen,
  output logic [DELTA_W-1:0] deltaMag,
  output logic               deltaNeg,
  output logic [START_W-1:0] startFreq,
  output logic               scanReset
);
  localparam int DHI_W = DELTA_W - HALF_W;

  logic              pairMode;
  logic [HALF_W-1:0] deltaStage;
  logic [HALF_W-1:0] startStage;

  assign pairMode = ctrlWord[HALF_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlWord         <= '0;
      stepCount        <= '0;
      intervalByCycles <= 1'b0;
      intervalMult     <= '0;
      intervalLen      <= '0;
      deltaMag         <= '0;
      deltaNeg         <= 1'b0;
      startFreq        <= '0;
      deltaStage       <= '0;
      startStage       <= '0;
      scanReset        <= 1'b0;
    end else begin
      scanReset <= strobes.wrCtrl;
      if (strobes.wrCtrl)  ctrlWord  <= strobes.data[HALF_W-1:0];
      if (strobes.wrCount) stepCount <= strobes.data[HALF_W-1:0];
      if (strobes.wrInterval)
        {intervalByCycles, intervalMult, intervalLen} <= strobes.data;
      if (strobes.wrDeltaLo) begin
        if (pairMode) deltaStage            <= strobes.data[HALF_W-1:0];
        else          deltaMag[HALF_W-1:0]  <= strobes.data[HALF_W-1:0];
      end
      if (strobes.wrDeltaHi) begin
        deltaNeg                       <= strobes.data[HALF_W-1];
        deltaMag[DELTA_W-1:HALF_W]     <= strobes.data[DHI_W-1:0];
        if (pairMode) deltaMag[HALF_W-1:0] <= deltaStage;
      end
      if (strobes.wrStartLo) begin
        if (pairMode) startStage            <= strobes.data[HALF_W-1:0];
        else          startFreq[HALF_W-1:0] <= strobes.data[HALF_W-1:0];
      end
      if (strobes.wrStartHi) begin
        startFreq[START_W-1:HALF_W] <= strobes.data[HALF_W-1:0];
        if (pairMode) startFreq[HALF_W-1:0] <= startStage;
      end
    end
  end

  a_r4_reset_follows_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrCtrl |=> scanReset);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scanReset |=> !scanReset);
  a_r8_delta_low_held: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrDeltaLo && pairMode) |=> ($stable(deltaMag) && $stable(deltaNeg)));
  a_r8_start_low_held: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrStartLo && pairMode) |=> $stable(startFreq));
  a_r7_start_low_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrStartLo && !pairMode) |=>
      (startFreq[HALF_W-1:0] == $past(strobes.data[HALF_W-1:0]))
      && $stable(startFreq[START_W-1:HALF_W]));
endmodule

// File: rtl/serLoadPort.sv
module serLoadPort
  import serload_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               serClk,
  input  logic               frameN,
  input  logic               serData,
  output logic [11:0]        ctrlWord,
  output logic [11:0]        stepCount,
  output logic               intervalByCycles,
  output logic [1:0]         intervalMult,
  output logic [10:0]        intervalLen,
  output logic [22:0]        deltaMag,
  output logic               deltaNeg,
  output logic [23:0]        startFreq,
  output logic               scanReset
);
  logic [WORD_W-1:0] wordHold;
  logic              wordToggle;
  regStrobes_t       strobes;

  serShifter u_shift (
    .rst_n      (rst_n),
    .serClk     (serClk),
    .frameN     (frameN),
    .serData    (serData),
    .wordHold   (wordHold),
    .wordToggle (wordToggle)
  );

  serControl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wordToggle (wordToggle),
    .wordHold   (wordHold),
    .strobes    (strobes)
  );

  serRegFile u_regs (
    .clk              (clk),
    .rst_n            (rst_n),
    .strobes          (strobes),
    .ctrlWord         (ctrlWord),
    .stepCount        (stepCount),
    .intervalByCycles (intervalByCycles),
    .intervalMult     (intervalMult),
    .intervalLen      (intervalLen),
    .deltaMag         (deltaMag),
    .deltaNeg         (deltaNeg),
    .startFreq        (startFreq),
    .scanReset        (scanReset)
  );
endmodule

// File: tb/tb_serLoadPort.sv
module tb_serLoadPort;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b1;
  logic frameN = 1'b1;
  logic serData = 1'b0;
  logic [11:0] ctrlWord, stepCount;
  logic        intervalByCycles;
  logic [1:0]  intervalMult;
  logic [10:0] intervalLen;
  logic [22:0] deltaMag;
  logic        deltaNeg;
  logic [23:0] startFreq;
  logic        scanReset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int pulses = 0;
  int widthErrs = 0;
  logic prevSr = 1'b0;

  // reference model
  logic [11:0] mCtrl = '0, mCount = '0, mDStage = '0, mSStage = '0;
  logic        mByCyc = 1'b0, mNeg = 1'b0;
  logic [1:0]  mMult = '0;
  logic [10:0] mLen = '0;
  logic [22:0] mDelta = '0;
  logic [23:0] mStart = '0;
  int          mPulses = 0;
  logic [15:0] sentQ[$];

  serLoadPort dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (scanReset) pulses++;
      if (scanReset && prevSr) widthErrs++;
      prevSr <= scanReset;
    end
  end

  task automatic checkEq(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    checkEq(tag, "ctrlWord", 32'(ctrlWord), 32'(mCtrl));
    checkEq(tag, "stepCount", 32'(stepCount), 32'(mCount));
    checkEq(tag, "interval", 32'({intervalByCycles, intervalMult, intervalLen}),
            32'({mByCyc, mMult, mLen}));
    checkEq(tag, "delta", 32'({deltaNeg, deltaMag}), 32'({mNeg, mDelta}));
    checkEq(tag, "startFreq", 32'(startFreq), 32'(mStart));
    checkEq(tag, "scanReset pulses", 32'(pulses), 32'(mPulses));
    checkEq(tag, "scanReset width", 32'(widthErrs), 32'd0);
  endtask

  task automatic applyModel(input logic [15:0] w);
    logic [11:0] p;
    p = w[11:0];
    casez (w[15:12])
      4'b0000: begin mCtrl = p; mPulses++; end
      4'b0001: mCount = p;
      4'b01??: {mByCyc, mMult, mLen} = w[13:0];
      4'b0010: if (mCtrl[11]) mDStage = p; else mDelta[11:0] = p;
      4'b0011: begin
        mNeg = p[11]; mDelta[22:12] = p[10:0];
        if (mCtrl[11]) mDelta[11:0] = mDStage;
      end
      4'b1100: if (mCtrl[11]) mSStage = p; else mStart[11:0] = p;
      4'b1101: begin
        mStart[23:12] = p;
        if (mCtrl[11]) mStart[11:0] = mSStage;
      end
      default: ;
    endcase
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk) serData = b;
    repeat (3) @(negedge clk);
    serClk = 1'b0;
    repeat (4) @(negedge clk);
    serClk = 1'b1;
  endtask

  task automatic sendBits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) shiftBit(w[15-i]);
  endtask

  task automatic beginFrame();
    @(negedge clk) frameN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic endFrame();
    repeat (2) @(negedge clk);
    frameN = 1'b1;
    repeat (20) @(negedge clk);
    while (sentQ.size() > 0) applyModel(sentQ.pop_front());
  endtask

  task automatic sendWord(input logic [15:0] w);
    sendBits(w, 16);
    sentQ.push_back(w);
  endtask

  task automatic writeWord(input logic [15:0] w);
    beginFrame();
    sendWord(w);
    endFrame();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R10");

    writeWord(16'h05A4); checkAll("R4");
    writeWord(16'h1ABC); checkAll("R5");
    writeWord(16'h67FF); checkAll("R6");
    writeWord(16'h59A3); checkAll("R6");

    writeWord(16'h2123); checkAll("R7");
    writeWord(16'h3ABC); checkAll("R7");
    writeWord(16'hC456); checkAll("R7");
    writeWord(16'hD789); checkAll("R7");
    writeWord(16'h3123); checkAll("R7");

    writeWord(16'h8FFF); checkAll("R9");
    writeWord(16'hB123); checkAll("R9");
    writeWord(16'hE555); checkAll("R9");
    writeWord(16'hF000); checkAll("R9");

    writeWord(16'h08F0); checkAll("R4");
    writeWord(16'h2F0F); checkAll("R8");
    writeWord(16'h33C3); checkAll("R8");
    writeWord(16'hCAAA); checkAll("R8");
    writeWord(16'hD555); checkAll("R8");

    // R2: three words in one frame
    beginFrame();
    sendWord(16'h1321);
    sendWord(16'h00FF);
    sendWord(16'hC111);
    endFrame();
    checkAll("R2");

    // R3: broken frame discarded, next frame realigned
    beginFrame();
    sendBits(16'h1FFF, 7);
    endFrame();
    checkAll("R3");
    writeWord(16'h100A); checkAll("R3");

    // R11: clock activity with frame high
    for (int i = 0; i < 16; i++) shiftBit(i[0]);
    repeat (20) @(negedge clk);
    checkAll("R11");
    writeWord(16'h1055); checkAll("R11");

    // R1: alternating-bit pattern through the shifter
    writeWord(16'h1AAA); checkAll("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule